// File: doc/BRIEF.md
# Block Cipher Register Control Unit

This block is the register-side controller that sits between a 32-bit bus register file and a block-cipher datapath. Software writes key words and input words one word at a time, in any order, through per-word write strobes. It reads result words through per-word read strobes. The controller tracks which words have been written and read, and decides when to hand a block to the cipher core. It also holds the finished result and reports progress in a four-bit status word.

There are two start policies. In automatic mode, a block starts as soon as every input word has been written since the last load. Completion then waits while the previous result is still unread. In manual mode, a block starts only on an explicit start trigger, and each new result overwrites the old one. The control word is held frozen while an operation is in flight, and so are the key words. The key-length field is cleaned up to a valid one-hot code. Self-clearing trigger bits start a block or wipe the key, input or output words.

The core is reached through a simple handshake. The controller pulses `core_start` with the key, state and mode on its outputs. The core raises `core_done` with its result and holds them until the controller answers with `core_accept`.

Top module: `cipher_regctl`

## Requirements
- R1: After reset, status reads 4'b1001 (bit 0 IDLE=1, bit 1 STALL=0, bit 2 OUTPUT_VALID=0, bit 3 INPUT_READY=1). The control word reads 5'b00010 (bit 0 decrypt=0, bits 3:1 key length=001, bit 4 manual=0). All output words are zero.
- R2: A written key-length field (control bits 3:1) is kept when it is 001, 100, or 010 with ALLOW_192=1. Every other value, including 000, codes with several bits set, and 010 with ALLOW_192=0, is stored as 001.
- R3: In automatic mode, a block starts in the cycle after the last of the four input words has been written at least once, in any order. INPUT_READY is 0 once any input word has been written and is not yet loaded. It returns to 1 when the block starts, and IDLE drops to 0 at the same time.
- R4: In manual mode, a block starts only after trigger bit 0 (START) is written as 1. In automatic mode, START is dropped without effect and clears itself, so a later switch to manual mode does not start a block.
- R5: In automatic mode, a finished block whose previous output is still unread is not committed, and status bit 1 (STALL) is 1. The stall ends once all four output words have each been read at least once, in any order. Repeated reads of one word do not count twice.
- R6: In manual mode, a finished block is committed at once, overwriting unread output, and STALL stays 0.
- R7: While IDLE is 0, writes to the control word and to the key words have no effect.
- R8: The trigger bits act once and clear themselves. Bit 1 zeroes the key words, bit 2 zeroes the input words and their write tracking, and bit 3 zeroes the output words and clears OUTPUT_VALID.
- R9: OUTPUT_VALID becomes 1 when a result is committed. It returns to 0 once all four output words have been read since that commit.
- R10: The core receives a one-cycle `core_start` with the loaded input words, the key words and the mode. Its result is copied to the output words in the cycle `core_accept` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_wdata | input | WORD_W | Write data for key and input words |
| key_we | input | NUM_KEY_WORDS | Per-word key write strobes |
| din_we | input | NUM_DATA_WORDS | Per-word input write strobes |
| dout_re | input | NUM_DATA_WORDS | Per-word output read strobes |
| dout_words | output | NUM_DATA_WORDS*WORD_W | Output words, word 0 in the low bits |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 5 | Control write data: bit 0 decrypt, bits 3:1 key length, bit 4 manual |
| ctrl_rdata | output | 5 | Stored control word |
| trig_we | input | 1 | Trigger write strobe |
| trig_wdata | input | 4 | Trigger bits: 0 start, 1 key wipe, 2 input wipe, 3 output wipe |
| status | output | 4 | {INPUT_READY, OUTPUT_VALID, STALL, IDLE} |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_op | output | 1 | Decrypt select to the core |
| core_keylen | output | 3 | One-hot key length to the core |
| core_key | output | NUM_KEY_WORDS*WORD_W | Key words to the core |
| core_state | output | NUM_DATA_WORDS*WORD_W | Input words loaded at start |
| core_done | input | 1 | Core result is ready and held |
| core_result | input | NUM_DATA_WORDS*WORD_W | Core result words |
| core_accept | output | 1 | Result taken this cycle |

## Verification
The assertions take for granted that the core keeps `core_done` and `core_result` steady from the moment it raises them until the cycle of `core_accept`. They also assume the core never raises `core_done` without a prior `core_start`. The bench core model drops its done flag exactly on the accept edge and answers each start with one result after a fixed latency. The assertions further rely on wipe triggers not arriving in the same cycle as a commit. The stimulus issues every wipe only while the unit is idle with no result pending.

// File: rtl/cipher_regctl_pkg.sv
package cipher_regctl_pkg;

  // control word layout: bit 4 manual, bits 3:1 key length, bit 0 decrypt
  typedef struct packed {
    logic       manual;
    logic [2:0] keylen;
    logic       decrypt;
  } ctrl_t;

  localparam int TRIG_W     = 4;
  localparam int TRIG_START = 0;
  localparam int TRIG_KWIPE = 1;
  localparam int TRIG_IWIPE = 2;
  localparam int TRIG_OWIPE = 3;

  localparam logic [2:0] KL_128 = 3'b001;
  localparam logic [2:0] KL_192 = 3'b010;
  localparam logic [2:0] KL_256 = 3'b100;

  function automatic logic [2:0] clean_keylen(input logic [2:0] raw, input bit allow192);
    if (raw == KL_128 || raw == KL_256 || (raw == KL_192 && allow192))
      return raw;
    return KL_128;
  endfunction

endpackage

// File: rtl/cr_word_bank.sv
module cr_word_bank #(
  parameter int NW = 4,
  parameter int W  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NW-1:0]   we,
  input  logic [W-1:0]    wdata,
  input  logic            wipe,
  input  logic            consume,
  output logic [NW*W-1:0] words,
  output logic [NW-1:0]   seen
);

  logic [W-1:0] mem [NW];

  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || wipe)   mem[i] <= '0;
      else if (we[i])    mem[i] <= wdata;
    end
    assign words[i*W +: W] = mem[i];
  end

  always_ff @(posedge clk) begin
    if (rst || wipe)   seen <= '0;
    else if (consume)  seen <= we;
    else               seen <= seen | we;
  end

  // R8: a wipe leaves every word and the tracking at zero
  a_r8_bank_wipe: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (seen == '0 && words == '0));

endmodule

// File: rtl/cr_out_bank.sv
module cr_out_bank #(
  parameter int NW = 4,
  parameter int W  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit,
  input  logic [NW*W-1:0] result,
  input  logic [NW-1:0]   re,
  input  logic            wipe,
  output logic [NW*W-1:0] words,
  output logic            valid
);

  logic [NW-1:0] rd_seen;
  logic [NW-1:0] rd_next;

  assign rd_next = rd_seen | re;

  always_ff @(posedge clk) begin
    if (rst) begin
      words   <= '0;
      valid   <= 1'b0;
      rd_seen <= '0;
    end else if (commit) begin
      words   <= result;
      valid   <= 1'b1;
      rd_seen <= '0;
    end else if (wipe) begin
      words   <= '0;
      valid   <= 1'b0;
      rd_seen <= '0;
    end else begin
      rd_seen <= rd_next;
      if (valid && (&rd_next)) valid <= 1'b0;
    end
  end

  // R9: a commit makes the result visible and valid
  a_r9_commit_valid: assert property (@(posedge clk) disable iff (rst)
    commit |=> (valid && words == $past(result)));

  // R8: output wipe zeroes the words
  a_r8_out_wipe: assert property (@(posedge clk) disable iff (rst)
    (wipe && !commit) |=> (!valid && words == '0));

endmodule

// File: rtl/cr_seq.sv
module cr_seq (
  input  logic clk,
  input  logic rst,
  input  logic manual,
  input  logic in_full,
  input  logic start_req,
  input  logic core_done,
  input  logic out_valid,
  output logic busy,
  output logic core_start,
  output logic launch,
  output logic commit,
  output logic stall
);

  assign launch = !busy && (manual ? start_req : in_full);
  assign commit = busy && core_done && (manual || !out_valid);
  assign stall  = busy && core_done && !manual && out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      core_start <= 1'b0;
    end else begin
      core_start <= launch;
      if (launch)      busy <= 1'b1;
      else if (commit) busy <= 1'b0;
    end
  end

  // R10: the start pulse lasts exactly one cycle
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);

  // R10: a launch is followed by a busy unit and a start pulse
  a_r10_launch_busy: assert property (@(posedge clk) disable iff (rst)
    launch |=> (busy && core_start));

endmodule

// File: rtl/cipher_regctl.sv
module cipher_regctl
  import cipher_regctl_pkg::*;
#(
  parameter int NUM_KEY_WORDS  = 8,
  parameter int NUM_DATA_WORDS = 4,
  parameter int WORD_W         = 32,
  parameter bit ALLOW_192      = 1'b0
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [WORD_W-1:0]                word_wdata,
  input  logic [NUM_KEY_WORDS-1:0]         key_we,
  input  logic [NUM_DATA_WORDS-1:0]        din_we,
  input  logic [NUM_DATA_WORDS-1:0]        dout_re,
  output logic [NUM_DATA_WORDS*WORD_W-1:0] dout_words,
  input  logic                             ctrl_we,
  input  logic [4:0]                       ctrl_wdata,
  output logic [4:0]                       ctrl_rdata,
  input  logic                             trig_we,
  input  logic [3:0]                       trig_wdata,
  output logic [3:0]                       status,
  output logic                             core_start,
  output logic                             core_op,
  output logic [2:0]                       core_keylen,
  output logic [NUM_KEY_WORDS*WORD_W-1:0]  core_key,
  output logic [NUM_DATA_WORDS*WORD_W-1:0] core_state,
  input  logic                             core_done,
  input  logic [NUM_DATA_WORDS*WORD_W-1:0] core_result,
  output logic                             core_accept
);

  localparam int KEY_BITS  = NUM_KEY_WORDS * WORD_W;
  localparam int DATA_BITS = NUM_DATA_WORDS * WORD_W;

  ctrl_t                    ctrl_q;
  logic [TRIG_W-1:0]        trig_q;
  logic [TRIG_W-1:0]        trig_done;
  logic                     busy, launch, commit, stall, out_valid;
  logic                     start_taken;
  logic [KEY_BITS-1:0]      key_words;
  logic [NUM_KEY_WORDS-1:0] key_seen;
  logic [DATA_BITS-1:0]     din_words;
  logic [NUM_DATA_WORDS-1:0] din_seen;

  // control word, frozen while an operation is in flight
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '{manual: 1'b0, keylen: KL_128, decrypt: 1'b0};
    end else if (ctrl_we && !busy) begin
      ctrl_q <= '{manual:  ctrl_wdata[4],
                  keylen:  clean_keylen(ctrl_wdata[3:1], ALLOW_192),
                  decrypt: ctrl_wdata[0]};
    end
  end

  // self-clearing triggers: wipes act for one cycle, start waits for idle
  assign start_taken = !ctrl_q.manual || launch;
  always_comb begin
    trig_done             = '1;
    trig_done[TRIG_START] = start_taken;
  end

  always_ff @(posedge clk) begin
    if (rst) trig_q <= '0;
    else     trig_q <= (trig_q & ~trig_done) | (trig_we ? trig_wdata : '0);
  end

  cr_word_bank #(.NW(NUM_KEY_WORDS), .W(WORD_W)) u_keys (
    .clk     (clk),
    .rst     (rst),
    .we      (key_we & {NUM_KEY_WORDS{!busy}}),
    .wdata   (word_wdata),
    .wipe    (trig_q[TRIG_KWIPE]),
    .consume (1'b0),
    .words   (key_words),
    .seen    (key_seen)
  );

  cr_word_bank #(.NW(NUM_DATA_WORDS), .W(WORD_W)) u_din (
    .clk     (clk),
    .rst     (rst),
    .we      (din_we),
    .wdata   (word_wdata),
    .wipe    (trig_q[TRIG_IWIPE]),
    .consume (launch),
    .words   (din_words),
    .seen    (din_seen)
  );

  cr_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .manual     (ctrl_q.manual),
    .in_full    (&din_seen),
    .start_req  (trig_q[TRIG_START]),
    .core_done  (core_done),
    .out_valid  (out_valid),
    .busy       (busy),
    .core_start (core_start),
    .launch     (launch),
    .commit     (commit),
    .stall      (stall)
  );

  cr_out_bank #(.NW(NUM_DATA_WORDS), .W(WORD_W)) u_dout (
    .clk    (clk),
    .rst    (rst),
    .commit (commit),
    .result (core_result),
    .re     (dout_re),
    .wipe   (trig_q[TRIG_OWIPE]),
    .words  (dout_words),
    .valid  (out_valid)
  );

  // core state is captured from the input words at launch
  always_ff @(posedge clk) begin
    if (rst)         core_state <= '0;
    else if (launch) core_state <= din_words;
  end

  assign core_key    = key_words;
  assign core_op     = ctrl_q.decrypt;
  assign core_keylen = ctrl_q.keylen;
  assign core_accept = commit;
  assign ctrl_rdata  = ctrl_q;
  assign status      = {~|din_seen, out_valid, stall, ~busy};

  // R7: the control word cannot change across a busy cycle
  a_r7_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ctrl_q));

  // R7: key words hold while busy unless a key wipe executes
  a_r7_keys_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && !trig_q[TRIG_KWIPE]) |=> ($stable(key_words) && $stable(key_seen)));

  // R2: the stored key length is always a single-bit code
  a_r2_keylen_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(ctrl_q.keylen) == 1);

  // R5: a stalled unit never hands the result over
  a_r5_stall_no_accept: assert property (@(posedge clk) disable iff (rst)
    status[1] |-> !core_accept);

endmodule

// File: tb/tb_cipher_regctl.sv
module tb_cipher_regctl;

  localparam int NK  = 8;
  localparam int ND  = 4;
  localparam int W   = 32;
  localparam int LAT = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic [W-1:0]    word_wdata;
  logic [NK-1:0]   key_we;
  logic [ND-1:0]   din_we, dout_re;
  logic [ND*W-1:0] dout_words;
  logic            ctrl_we, trig_we;
  logic [4:0]      ctrl_wdata, ctrl_rdata;
  logic [3:0]      trig_wdata, status;
  logic            core_start, core_op, core_done, core_accept;
  logic [2:0]      core_keylen;
  logic [NK*W-1:0] core_key;
  logic [ND*W-1:0] core_state, core_result;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cipher_regctl dut (
    .clk(clk), .rst(rst), .word_wdata(word_wdata), .key_we(key_we),
    .din_we(din_we), .dout_re(dout_re), .dout_words(dout_words),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .status(status),
    .core_start(core_start), .core_op(core_op), .core_keylen(core_keylen),
    .core_key(core_key), .core_state(core_state), .core_done(core_done),
    .core_result(core_result), .core_accept(core_accept)
  );

  function automatic logic [ND*W-1:0] mix(input logic [ND*W-1:0] st,
                                          input logic [NK*W-1:0] k,
                                          input logic op);
    logic [ND*W-1:0] r;
    for (int i = 0; i < ND; i++)
      r[i*W +: W] = st[i*W +: W] ^ k[i*W +: W] ^ k[(i+ND)*W +: W] ^ {W{op}};
    return r;
  endfunction

  // fixed-latency core model
  int cnt;
  always @(posedge clk) begin
    if (rst) begin
      cnt <= 0; core_done <= 1'b0; core_result <= '0;
    end else begin
      if (core_start) begin
        cnt <= LAT;
        core_result <= mix(core_state, core_key, core_op);
      end else if (cnt > 1) cnt <= cnt - 1;
      else if (cnt == 1) begin core_done <= 1'b1; cnt <= 0; end
      if (core_done && core_accept) core_done <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [ND*W-1:0] act, input logic [ND*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [ND*W-1:0] expq[$];
  logic [W-1:0] key_m [NK];
  logic [W-1:0] din_m [ND];
  logic op_m;

  function automatic logic [ND*W-1:0] expect_now();
    logic [ND*W-1:0] st;
    logic [NK*W-1:0] k;
    for (int i = 0; i < ND; i++) st[i*W +: W] = din_m[i];
    for (int i = 0; i < NK; i++) k[i*W +: W] = key_m[i];
    return mix(st, k, op_m);
  endfunction

  initial begin : monitor
    bit pend = 0;
    forever begin
      @(negedge clk);
      if (pend) begin
        pend = 0;
        if (expq.size() == 0) chk("R10 result without expectation", dout_words, '0 - 1);
        else chk("R10 R3 R6 R8 result", dout_words, expq.pop_front());
      end
      if (!rst && core_accept) pend = 1;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [4:0] v);
    ctrl_we = 1; ctrl_wdata = v; cyc(1); ctrl_we = 0;
  endtask

  task automatic wr_key(input int i, input logic [W-1:0] v);
    key_we = '0; key_we[i] = 1'b1; word_wdata = v; cyc(1); key_we = '0;
  endtask

  task automatic wr_din(input int i, input logic [W-1:0] v);
    din_we = '0; din_we[i] = 1'b1; word_wdata = v; din_m[i] = v; cyc(1); din_we = '0;
  endtask

  task automatic rd_out(input int i);
    dout_re = '0; dout_re[i] = 1'b1; cyc(1); dout_re = '0;
  endtask

  task automatic trig(input logic [3:0] v);
    trig_we = 1; trig_wdata = v; cyc(1); trig_we = 0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 50; n++) begin
      if (status[0]) break;
      cyc(1);
    end
  endtask

  initial begin : stim
    bit saw_stall;
    rst = 1; word_wdata = '0; key_we = '0; din_we = '0; dout_re = '0;
    ctrl_we = 0; ctrl_wdata = '0; trig_we = 0; trig_wdata = '0;
    for (int i = 0; i < NK; i++) key_m[i] = '0;
    for (int i = 0; i < ND; i++) din_m[i] = '0;
    cyc(3); rst = 0; cyc(1);

    chk("R1 status", status, 4'b1001);
    chk("R1 ctrl", ctrl_rdata, 5'b00010);
    chk("R1 dout", dout_words, '0);

    wr_ctrl(5'b0_000_0); chk("R2 zero code", ctrl_rdata, 5'b0_001_0);
    wr_ctrl(5'b0_110_1); chk("R2 two bits", ctrl_rdata, 5'b0_001_1);
    wr_ctrl(5'b1_100_0); chk("R2 256 kept", ctrl_rdata, 5'b1_100_0);
    wr_ctrl(5'b0_010_0); chk("R2 192 disabled", ctrl_rdata, 5'b0_001_0);
    wr_ctrl(5'b0_100_1); chk("R2 final", ctrl_rdata, 5'b0_100_1);
    op_m = 1;

    for (int i = 0; i < NK; i++) begin
      key_m[i] = 32'hA5A5_0000 + 32'(i * 32'h111);
      wr_key(i, key_m[i]);
    end

    // R3: automatic start, any order
    wr_din(3, 32'h3333_0003); wr_din(0, 32'h0000_1000); wr_din(2, 32'h2222_0202);
    chk("R3 partial not started", status, 4'b0001);
    wr_din(1, 32'h1111_0011);
    chk("R3 full but not yet started", status[0], 1'b1);
    expq.push_back(expect_now());
    cyc(1);
    chk("R3 started", status, 4'b1000);

    // R7: writes during busy ignored
    wr_ctrl(5'b1_001_0);
    wr_key(0, 32'hDEAD_BEEF);
    wait_idle(); cyc(1);
    chk("R7 ctrl unchanged", ctrl_rdata, 5'b0_100_1);
    chk("R9 valid after commit", status, 4'b1101);

    // R5: stall with unread output
    wr_din(2, 32'h0BAD_0002); wr_din(1, 32'h0BAD_0001);
    wr_din(3, 32'h0BAD_0003); wr_din(0, 32'h0BAD_0000);
    expq.push_back(expect_now());
    for (int n = 0; n < 20 && !status[1]; n++) cyc(1);
    chk("R5 stalled", {status[1], status[0]}, 2'b10);
    rd_out(0); rd_out(0); rd_out(2); rd_out(1);
    chk("R5 still stalled after partial reads", {status[2], status[1]}, 2'b11);
    rd_out(3);
    chk("R5 stall released", status[1], 1'b0);
    cyc(1);
    chk("R5 committed", status, 4'b1101);

    // R9: reading all words clears OUTPUT_VALID
    rd_out(1); rd_out(3); rd_out(0); rd_out(2);
    chk("R9 valid cleared", status, 4'b1001);

    // R4/R6: manual mode
    wr_ctrl(5'b1_100_0); op_m = 0;
    for (int i = 0; i < ND; i++) wr_din(i, 32'hC0DE_0000 + 32'(i));
    cyc(6);
    chk("R4 no start without trigger", status, 4'b0001);
    trig(4'b0001);
    expq.push_back(expect_now());
    cyc(1);
    chk("R4 started on trigger", status[0], 1'b0);
    wait_idle();
    saw_stall = 0;
    for (int i = 0; i < ND; i++) wr_din(i, 32'hF00D_0000 + 32'(i * 7));
    trig(4'b0001);
    expq.push_back(expect_now());
    for (int n = 0; n < 20; n++) begin
      if (status[1]) saw_stall = 1;
      cyc(1);
    end
    chk("R6 no stall in manual", saw_stall, 1'b0);
    chk("R6 overwrite valid", status, 4'b1101);

    // R4: START ignored in automatic mode and cleared
    wr_ctrl(5'b0_100_0);
    wr_din(0, 32'h7); wr_din(1, 32'h8);
    trig(4'b0001);
    cyc(5);
    chk("R4 auto ignores start", status[0], 1'b1);
    wr_ctrl(5'b1_100_1); op_m = 1;
    cyc(5);
    chk("R4 start not retained", status[0], 1'b1);

    // R8: wipes
    trig(4'b0100); cyc(1);
    for (int i = 0; i < ND; i++) din_m[i] = '0;
    chk("R8 input wipe", status[3], 1'b1);
    trig(4'b1000); cyc(1);
    chk("R8 output wipe words", dout_words, '0);
    chk("R8 output wipe valid", status[2], 1'b0);
    trig(4'b0010); cyc(1);
    for (int i = 0; i < NK; i++) key_m[i] = '0;
    trig(4'b0001);
    expq.push_back(expect_now());
    cyc(2); wait_idle(); cyc(2);
    chk("R8 zero state and key result drained", 32'(expq.size()), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule